// File: doc/BRIEF.md
# Dual-Channel Storage Access Router

This block sits behind the host I/O decoder of a two-channel disk controller. The host presents one access per cycle. Each access carries a window index (0 to 4), a byte offset, a size of 1, 2 or 4 bytes, a read/write flag and write data. The router sends the access to one of six targets: the task-file or alternate-status port of either channel, or either channel's bus-master register window. It can also absorb the access without forwarding it. It keeps a drive-select bit for each channel by watching writes to the drive/head register. It also combines the interrupt requests of the two channels into one shared line.

The routing result is held in a registered outcome state machine. `ST_IDLE` is taken when there is no request, `ST_FWD` when the access goes to a target, `ST_ZERO` when a read hits an empty drive slot and returns zero, `ST_DISCARD` when a write is silently dropped, and `ST_REJECT` when the access is malformed. From any state the machine moves on each clock to the state named by the decode of the current request, or to `ST_IDLE` if there is none. The shared interrupt is a second machine with states `IRQ_LOW` and `IRQ_HIGH`. A post moves it LOW→HIGH when the other channel has nothing pending. A clear moves it HIGH→LOW when the other channel has nothing pending.

Top module: `ide_access_router`

## Requirements
- R1: Window 0 goes to port code 0 (primary task file), window 1 to code 1 (primary alternate status), window 2 to code 2 (secondary task file) and window 3 to code 3 (secondary alternate status); the outcome code for a forward is 1.
- R2: The offset forwarded on window 0 is the request offset shifted right by `IO_SHIFT`; on window 1 it is the request offset plus `CTRL_OFFSET`, modulo 2^`OFFSET_W`; on windows 2 and 3 it is unchanged.
- R3: On window 4, offsets below 8 go to port code 4 (primary bus master) unchanged, and offsets of 8 or more go to port code 5 (secondary bus master) with 8 subtracted; the forwarded drive bit is 0.
- R4: A window-4 write while `bm_enable` is 0 gives outcome 3 (discard); window-4 reads are forwarded whatever `bm_enable` is.
- R5: A write on a task-file window whose adjusted offset is 6 sets that channel's select bit to data bit 4 (mask 0x10) before routing. The same access already uses the new drive. Both channels select drive 0 after reset. `sel_dev[c]` shows channel c.
- R6: When the selected drive slot is empty, a 1-byte read gives outcome 2 (zero data), a 1-byte write gives outcome 3 (discard), and any other size gives outcome 4 (reject).
- R7: A size other than 1, 2 or 4, or a window index above 4, gives outcome 4 and leaves the select bits unchanged.
- R8: Slot presence is `dev_present[2*c + d]` for channel c (0 primary, 1 secondary) and drive d.
- R9: A post on a channel drives `irq_out` high on the next cycle.
- R10: A clear on a channel drives `irq_out` low on the next cycle only when the other channel has no pending request; otherwise the line stays high.
- R11: The outcome appears one cycle after the request. With no request, `out_kind` is 0 and all `fwd_*` outputs are 0; they are also 0 for every outcome other than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_bar | input | 3 | Window index |
| req_offset | input | OFFSET_W | Byte offset within window |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| bm_enable | input | 1 | Bus-master enable from the function's command register |
| dev_present | input | 4 | Drive slot population |
| irq_post | input | 2 | Per-channel interrupt post pulse |
| irq_clear | input | 2 | Per-channel interrupt clear pulse |
| out_kind | output | 3 | Outcome: 0 idle, 1 forward, 2 zero read, 3 discard, 4 reject |
| fwd_port | output | 3 | Target port code |
| fwd_dev | output | 1 | Drive selected on the target channel |
| fwd_offset | output | OFFSET_W | Adjusted offset |
| fwd_size | output | 3 | Forwarded size |
| fwd_write | output | 1 | Forwarded direction |
| fwd_wdata | output | DATA_W | Forwarded write data |
| sel_dev | output | 2 | Current drive select per channel |
| irq_out | output | 1 | Shared interrupt line |

## Verification
The bench sweeps every window index, every size code from 0 to 7, reads and writes, and a set of offsets. The offsets include the select offset before and after shifting, and both sides of the bus-master split. These sweeps are repeated for five slot-population patterns and for both settings of the bus-master enable. The population patterns tell apart a correct slot index from a swapped channel or drive bit. Write data alternates bit 4, so the select register toggles: a stale select shows up as a wrong drive or a wrong empty-slot outcome. Directed interrupt sequences overlap posts and clears on both channels. They separate shared-line handling from a plain per-channel copy.

// File: rtl/ide_router_pkg.sv
package ide_router_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FWD     = 3'd1,
        ST_ZERO    = 3'd2,
        ST_DISCARD = 3'd3,
        ST_REJECT  = 3'd4
    } route_state_e;

    typedef enum logic [2:0] {
        PT_PRI_TF  = 3'd0,
        PT_PRI_ALT = 3'd1,
        PT_SEC_TF  = 3'd2,
        PT_SEC_ALT = 3'd3,
        PT_PRI_BM  = 3'd4,
        PT_SEC_BM  = 3'd5
    } route_port_e;

    typedef enum logic {
        IRQ_LOW  = 1'b0,
        IRQ_HIGH = 1'b1
    } irq_state_e;

    localparam int unsigned NUM_CH      = 2;
    localparam int unsigned DRV_PER_CH  = 2;
    localparam int unsigned SEL_REG_OFF = 6;
    localparam int unsigned SEL_BIT     = 4;
    localparam int unsigned BM_BAR      = 4;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/ide_route_decode.sv
module ide_route_decode
    import ide_router_pkg::*;
#(
    parameter int unsigned OFFSET_W    = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned IO_SHIFT    = 0,
    parameter int unsigned CTRL_OFFSET = 0,
    parameter int unsigned BM_WIN      = 8
) (
    input  logic [2:0]          req_bar,
    input  logic [OFFSET_W-1:0] req_offset,
    input  logic [2:0]          req_size,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                bm_enable,
    input  logic [NUM_CH*DRV_PER_CH-1:0] dev_present,
    input  logic [NUM_CH-1:0]   sel_cur,
    output route_state_e        dec_kind,
    output route_port_e         dec_port,
    output logic                dec_dev,
    output logic [OFFSET_W-1:0] dec_offset,
    output logic [NUM_CH-1:0]   sel_wr,
    output logic                sel_val
);

    localparam logic [OFFSET_W-1:0] SEL_OFF_L = OFFSET_W'(SEL_REG_OFF);
    localparam logic [OFFSET_W-1:0] BM_WIN_L  = OFFSET_W'(BM_WIN);
    localparam logic [OFFSET_W-1:0] CTRL_ADD  = OFFSET_W'(CTRL_OFFSET);

    logic [OFFSET_W-1:0] adj_off;
    logic                ch;
    logic                is_tf;
    logic                drv;
    logic [1:0]          slot;

    // window-specific offset adjustment
    always_comb begin
        case (req_bar)
            3'd0:    adj_off = req_offset >> IO_SHIFT;
            3'd1:    adj_off = req_offset + CTRL_ADD;
            default: adj_off = req_offset;
        endcase
    end

    assign ch    = req_bar[1];
    assign is_tf = ~req_bar[0];

    always_comb begin
        dec_kind   = ST_REJECT;
        dec_port   = PT_PRI_TF;
        dec_dev    = 1'b0;
        dec_offset = '0;
        sel_wr     = '0;
        sel_val    = req_wdata[SEL_BIT];
        drv        = 1'b0;
        slot       = 2'd0;
        if (!size_legal(req_size)) begin
            dec_kind = ST_REJECT;
        end else if (req_bar == 3'(BM_BAR)) begin
            if (req_write && !bm_enable) begin
                dec_kind = ST_DISCARD;
            end else begin
                dec_kind = ST_FWD;
                if (req_offset < BM_WIN_L) begin
                    dec_port   = PT_PRI_BM;
                    dec_offset = req_offset;
                end else begin
                    dec_port   = PT_SEC_BM;
                    dec_offset = req_offset - BM_WIN_L;
                end
            end
        end else if (req_bar < 3'(BM_BAR)) begin
            // snoop the drive/head register before routing
            if (is_tf && req_write && (adj_off == SEL_OFF_L)) begin
                sel_wr[ch] = 1'b1;
            end
            drv  = sel_wr[ch] ? sel_val : sel_cur[ch];
            slot = {ch, drv};
            if (!dev_present[slot]) begin
                if (req_size != 3'd1)
                    dec_kind = ST_REJECT;
                else if (req_write)
                    dec_kind = ST_DISCARD;
                else
                    dec_kind = ST_ZERO;
            end else begin
                dec_kind   = ST_FWD;
                dec_port   = route_port_e'(req_bar);
                dec_dev    = drv;
                dec_offset = adj_off;
            end
        end
    end

endmodule

// File: rtl/ide_dev_select.sv
module ide_dev_select (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    output logic sel_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else if (wr_en)
            sel_q <= wr_val;
    end

    // R5: selection only moves on a snooped select write
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));

    p_sel_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel_q == $past(wr_val)));

endmodule

// File: rtl/ide_irq_merge.sv
module ide_irq_merge
    import ide_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_post,
    input  logic [NUM_CH-1:0] irq_clear,
    output logic              irq_out
);

    irq_state_e        st_q, st_d;
    logic [NUM_CH-1:0] pend_q, pend_d;

    // channels are handled in index order; a post beats a clear on one channel
    always_comb begin
        pend_d = pend_q;
        st_d   = st_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (irq_post[c]) begin
                pend_d[c] = 1'b1;
                if (!pend_d[NUM_CH-1-c]) st_d = IRQ_HIGH;
            end else if (irq_clear[c]) begin
                pend_d[c] = 1'b0;
                if (!pend_d[NUM_CH-1-c]) st_d = IRQ_LOW;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= IRQ_LOW;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        unique case (st_q)
            IRQ_LOW:  irq_out = 1'b0;
            IRQ_HIGH: irq_out = 1'b1;
            default:  irq_out = 1'b0;
        endcase
    end

    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_post) |=> irq_out);

    p_irq_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_post == '0 && pend_q == 2'b11 && irq_clear != 2'b11) |=> irq_out);

    p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_post == '0 && (pend_q & ~irq_clear) == '0) |=> !irq_out);

endmodule

// File: rtl/ide_access_router.sv
module ide_access_router
    import ide_router_pkg::*;
#(
    parameter int unsigned OFFSET_W    = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned IO_SHIFT    = 0,
    parameter int unsigned CTRL_OFFSET = 0,
    parameter int unsigned BM_WIN      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_bar,
    input  logic [OFFSET_W-1:0] req_offset,
    input  logic [2:0]          req_size,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                bm_enable,
    input  logic [3:0]          dev_present,
    input  logic [1:0]          irq_post,
    input  logic [1:0]          irq_clear,
    output logic [2:0]          out_kind,
    output logic [2:0]          fwd_port,
    output logic                fwd_dev,
    output logic [OFFSET_W-1:0] fwd_offset,
    output logic [2:0]          fwd_size,
    output logic                fwd_write,
    output logic [DATA_W-1:0]   fwd_wdata,
    output logic [1:0]          sel_dev,
    output logic                irq_out
);

    route_state_e        dec_kind;
    route_port_e         dec_port;
    logic                dec_dev;
    logic [OFFSET_W-1:0] dec_offset;
    logic [NUM_CH-1:0]   sel_wr;
    logic                sel_val;
    logic [NUM_CH-1:0]   sel_q;

    route_state_e        state_q;
    route_port_e         pay_port;
    logic                pay_dev;
    logic [OFFSET_W-1:0] pay_offset;
    logic [2:0]          pay_size;
    logic                pay_write;
    logic [DATA_W-1:0]   pay_wdata;

    ide_route_decode #(
        .OFFSET_W   (OFFSET_W),
        .DATA_W     (DATA_W),
        .IO_SHIFT   (IO_SHIFT),
        .CTRL_OFFSET(CTRL_OFFSET),
        .BM_WIN     (BM_WIN)
    ) u_decode (
        .req_bar    (req_bar),
        .req_offset (req_offset),
        .req_size   (req_size),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .bm_enable  (bm_enable),
        .dev_present(dev_present),
        .sel_cur    (sel_q),
        .dec_kind   (dec_kind),
        .dec_port   (dec_port),
        .dec_dev    (dec_dev),
        .dec_offset (dec_offset),
        .sel_wr     (sel_wr),
        .sel_val    (sel_val)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        ide_dev_select u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (req_valid & sel_wr[c]),
            .wr_val(sel_val),
            .sel_q (sel_q[c])
        );
    end

    ide_irq_merge u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_post (irq_post),
        .irq_clear(irq_clear),
        .irq_out  (irq_out)
    );

    // outcome state register with captured payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pay_port   <= PT_PRI_TF;
            pay_dev    <= 1'b0;
            pay_offset <= '0;
            pay_size   <= '0;
            pay_write  <= 1'b0;
            pay_wdata  <= '0;
        end else begin
            state_q    <= req_valid ? dec_kind : ST_IDLE;
            pay_port   <= dec_port;
            pay_dev    <= dec_dev;
            pay_offset <= dec_offset;
            pay_size   <= req_size;
            pay_write  <= req_write;
            pay_wdata  <= req_wdata;
        end
    end

    // outputs from state
    always_comb begin
        out_kind   = 3'(state_q);
        fwd_port   = '0;
        fwd_dev    = 1'b0;
        fwd_offset = '0;
        fwd_size   = '0;
        fwd_write  = 1'b0;
        fwd_wdata  = '0;
        unique case (state_q)
            ST_FWD: begin
                fwd_port   = 3'(pay_port);
                fwd_dev    = pay_dev;
                fwd_offset = pay_offset;
                fwd_size   = pay_size;
                fwd_write  = pay_write;
                fwd_wdata  = pay_wdata;
            end
            ST_IDLE, ST_ZERO, ST_DISCARD, ST_REJECT: ;
            default: ;
        endcase
    end

    assign sel_dev = sel_q;

    p_bm_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 3'd1 && fwd_write && fwd_port >= 3'd4) |-> $past(bm_enable));

    p_bad_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !size_legal(req_size)) |=> (out_kind == 3'd4));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (out_kind == 3'd0 && fwd_port == 3'd0 && !fwd_write));

    p_zero_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 3'd2) |-> ($past(req_size) == 3'd1 && !$past(req_write)));

endmodule

// File: tb/ide_access_router_bench.sv
module ide_access_router_bench;

    localparam int OW = 8;
    localparam int DW = 32;
    localparam int SH = 1;
    localparam int CA = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [2:0]    req_bar;
    logic [OW-1:0] req_offset;
    logic [2:0]    req_size;
    logic          req_write;
    logic [DW-1:0] req_wdata;
    logic          bm_enable;
    logic [3:0]    dev_present;
    logic [1:0]    irq_post;
    logic [1:0]    irq_clear;
    logic [2:0]    out_kind;
    logic [2:0]    fwd_port;
    logic          fwd_dev;
    logic [OW-1:0] fwd_offset;
    logic [2:0]    fwd_size;
    logic          fwd_write;
    logic [DW-1:0] fwd_wdata;
    logic [1:0]    sel_dev;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    logic [1:0] m_sel = 2'b00;

    always #10 clk = ~clk;

    ide_access_router #(
        .OFFSET_W(OW), .DATA_W(DW), .IO_SHIFT(SH), .CTRL_OFFSET(CA), .BM_WIN(8)
    ) u_ide_access_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bar(req_bar),
        .req_offset(req_offset), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .bm_enable(bm_enable), .dev_present(dev_present),
        .irq_post(irq_post), .irq_clear(irq_clear), .out_kind(out_kind),
        .fwd_port(fwd_port), .fwd_dev(fwd_dev), .fwd_offset(fwd_offset),
        .fwd_size(fwd_size), .fwd_write(fwd_write), .fwd_wdata(fwd_wdata),
        .sel_dev(sel_dev), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input int bar, input int off, input int sz, input bit wr, input bit d4);
        int kind = 0; int port = 0; int dev = 0; int eoff = 0;
        int ch; int slot;
        string tag;
        logic [DW-1:0] wd;
        wd = {24'h5a5a00, 3'b000, d4, 4'h3};
        // bench model of the routing rules
        if (bar > 4 || !(sz == 1 || sz == 2 || sz == 4)) begin
            kind = 4; tag = "R7";
        end else if (bar == 4) begin
            if (wr && !bm_enable) begin kind = 3; tag = "R4"; end
            else begin
                kind = 1; tag = "R3";
                if (off < 8) begin port = 4; eoff = off; end
                else begin port = 5; eoff = off - 8; end
            end
        end else begin
            ch = bar / 2;
            if (bar == 0) eoff = off / (1 << SH);
            else if (bar == 1) eoff = (off + CA) % 256;
            else eoff = off;
            if (bar % 2 == 0 && wr && eoff == 6) m_sel[ch] = d4;
            dev = int'(m_sel[ch]);
            slot = ch * 2 + dev;                       // R8 slot index
            if (!dev_present[slot]) begin
                tag = "R6/R8";
                if (sz != 1) kind = 4; else if (wr) kind = 3; else kind = 2;
                eoff = 0; dev = 0;
            end else begin
                kind = 1; port = bar; tag = "R1/R2/R8";
            end
        end
        if (kind != 1) begin port = 0; dev = 0; eoff = 0; end
        @(negedge clk);
        req_valid = 1'b1; req_bar = 3'(bar); req_offset = OW'(off);
        req_size = 3'(sz); req_write = wr; req_wdata = wd;
        @(negedge clk);
        check(tag,
              {21'd0, out_kind, fwd_port, fwd_dev, fwd_offset, fwd_size, fwd_write, fwd_wdata},
              {21'd0, 3'(kind), 3'(port), 1'(dev), OW'(eoff),
               (kind == 1) ? 3'(sz) : 3'd0, (kind == 1) ? wr : 1'b0,
               (kind == 1) ? wd : {DW{1'b0}}});
        check("R5 select", {62'd0, sel_dev}, {62'd0, m_sel});
        req_valid = 1'b0;
    endtask

    task automatic irq_step(input logic [1:0] p, input logic [1:0] c, input bit exp, input string tag);
        @(negedge clk);
        irq_post = p; irq_clear = c;
        @(negedge clk);
        irq_post = 2'b00; irq_clear = 2'b00;
        check(tag, {63'd0, irq_out}, {63'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int offs[6];
        logic [3:0] pats[5];
        offs = '{0, 6, 9, 12, 13, 3};
        pats = '{4'hF, 4'h5, 4'hA, 4'h0, 4'h6};
        rst_n = 1'b0; req_valid = 1'b0; req_bar = '0; req_offset = '0;
        req_size = '0; req_write = 1'b0; req_wdata = '0; bm_enable = 1'b1;
        dev_present = 4'hF; irq_post = '0; irq_clear = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset kind", {61'd0, out_kind}, 64'd0);
        check("R5 reset select", {62'd0, sel_dev}, 64'd0);
        check("R9 reset irq", {63'd0, irq_out}, 64'd0);

        for (int p = 0; p < 5; p++) begin
            dev_present = pats[p];
            for (int b = 0; b < 2; b++) begin
                bm_enable = b[0];
                for (int bar = 0; bar < 6; bar++)
                    for (int sz = 0; sz < 8; sz++)
                        for (int w = 0; w < 2; w++)
                            for (int o = 0; o < 6; o++)
                                access(bar, offs[o], sz, w[0], ((bar + sz + o + p) % 2) == 1);
            end
        end

        // R11: idle cycle after a request
        @(negedge clk);
        check("R11 idle", {61'd0, out_kind, fwd_write}, 64'd0);

        // R9 / R10 interrupt sequences
        irq_step(2'b01, 2'b00, 1'b1, "R9 post primary");
        irq_step(2'b10, 2'b00, 1'b1, "R9 post secondary");
        irq_step(2'b00, 2'b01, 1'b1, "R10 clear primary other pending");
        irq_step(2'b00, 2'b10, 1'b0, "R10 clear secondary last");
        irq_step(2'b10, 2'b00, 1'b1, "R9 post secondary alone");
        irq_step(2'b00, 2'b10, 1'b0, "R10 clear secondary alone");
        irq_step(2'b11, 2'b00, 1'b1, "R9 post both");
        irq_step(2'b00, 2'b11, 1'b0, "R10 clear both");
        irq_step(2'b10, 2'b01, 1'b1, "R9 post with other clear");
        irq_step(2'b00, 2'b01, 1'b1, "R10 clear idle channel");
        irq_step(2'b00, 2'b10, 1'b0, "R10 final clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule